// File: doc/BRIEF.md
# Dual-Slope PWM Compare Unit

This block is an up/down timer with two compare channels, built for symmetric (phase-correct) pulse-width modulation. The counter climbs from 0 to a programmable TOP value, turns, and descends back to 0. It shows each end value for exactly one clock. A direction flag tells whether the counter is on its falling slope. Each channel compares the count against its own compare value and drives one waveform pin.

Each channel has a two-bit output-mode code. The code either routes a plain port-data bit to the pin or lets the compare logic drive the pin. When the compare logic drives the pin, a match on the rising slope and a match on the falling slope have opposite effects, so the pulse stays centred in the period. The toggle code works only on channel A, and only while a separate mode-select input is high. For channel B that code always leaves the pin on port data.

The compare inputs are double-buffered. Software may write them at any time. The internal compare value changes only at the turning point at TOP, so a period never sees a mix of two values. All outputs are registered, and a synchronous active-high reset clears them.

Top module: `pwm_dual_slope`

## Requirements
- R1: When `top_val` > 0, the counter counts by one from 0 up to `top_val` and then by one back down to 0, and repeats. Each end value is shown for one clock. When `top_val` is 0, the counter holds at 0.
- R2: `dir_down` is 1 from the cycle where the count equals TOP down to the cycle showing 1, and 0 from the cycle showing 0 up to TOP−1. It is always 0 when `top_val` is 0.
- R3: Mode code 2'b00 on either channel drives the pin with that channel's port-data bit, one clock later.
- R4: Mode code 2'b01 acts as follows. With `a_toggle_en` = 0, both channels pass port data through as in R3. With `a_toggle_en` = 1, pin A inverts one clock after every cycle where the count equals channel A's compare value, on both slopes. Channel B with code 2'b01 always passes port data through.
- R5: Mode code 2'b10 clears the channel state on a match while counting up and sets it on a match while counting down. Once a period has settled, the pin one clock after a cycle with count c equals (c < OCR) on the rising slope and (c <= OCR) on the falling slope.
- R6: Mode code 2'b11 is the inverse of R5. It sets the channel state on a rising-slope match and clears it on a falling-slope match, so the settled pin is the complement of the R5 level.
- R7: A match in the cycle where the count equals TOP counts as a falling-slope match. As a result, with OCR = TOP the pin stays high for code 2'b10 and low for code 2'b11, and with OCR = 0 it stays low for 2'b10 and high for 2'b11.
- R8: The internal compare value of each channel loads from its compare input on the clock edge where the count equals TOP. It is used from the next cycle on and holds at all other edges.
- R9: An internal compare value above TOP never matches, so a pin under code 2'b10 or 2'b11 keeps its level.
- R10: Synchronous reset sets the count to 0, `dir_down` to 0, both internal compare values to 0, both channel states to 0, and both pins to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| top_val | input | CNT_W | Turning point of the count |
| cmp_a | input | CNT_W | Compare input, channel A (buffered) |
| cmp_b | input | CNT_W | Compare input, channel B (buffered) |
| mode_a | input | 2 | Output-mode code, channel A |
| mode_b | input | 2 | Output-mode code, channel B |
| a_toggle_en | input | 1 | Enables the toggle code on channel A |
| port_a | input | 1 | Port-data bit shown on pin A when disconnected |
| port_b | input | 1 | Port-data bit shown on pin B when disconnected |
| pin_a | output | 1 | Waveform pin, channel A |
| pin_b | output | 1 | Waveform pin, channel B |
| count | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 while on the falling slope |

## Verification
Count and direction are due at the first edge after the previous state. Each pin is due one edge after the cycle whose count, direction, internal compare value and port bit decide it. A compare input takes effect only from the cycle after the one in which the count shows TOP. The bench keeps a model state equal to what the design holds between edges. At each falling edge it first computes the values due at the coming rising edge from that state and the inputs it has just applied. It then compares the design's outputs at the next falling edge. The waveform levels of R5 and R6 are checked only after two full periods, because the compare value in force right after reset is 0.

// File: rtl/pwm_ds_pkg.sv
package pwm_ds_pkg;

  typedef enum logic [1:0] {
    OM_PORT   = 2'b00,
    OM_TOGGLE = 2'b01,
    OM_CLR_UP = 2'b10,
    OM_SET_UP = 2'b11
  } out_mode_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/pwm_ds_counter.sv
module pwm_ds_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             at_top
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W:0] inc_w;
  logic           top_zero;
  logic           reach_top;
  logic           reach_bot;

  always_comb begin
    inc_w     = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
    top_zero  = (top_val == '0);
    reach_top = (inc_w >= {1'b0, top_val});
    reach_bot = (count <= ONE);
    at_top    = (count == top_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else if (top_zero) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else if (!dir_down) begin
      if (reach_top) begin
        count    <= top_val;
        dir_down <= 1'b1;
      end else begin
        count    <= inc_w[CNT_W-1:0];
      end
    end else begin
      if (reach_bot) begin
        count    <= '0;
        dir_down <= 1'b0;
      end else begin
        count    <= count - ONE;
      end
    end
  end

endmodule

// File: rtl/pwm_ds_cmp_buf.sv
module pwm_ds_cmp_buf #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] ocr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_q <= '0;
    end else if (load) begin
      ocr_q <= din;
    end
  end

endmodule

// File: rtl/pwm_ds_wave_ch.sv
module pwm_ds_wave_ch
  import pwm_ds_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit TOGGLE_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             toggle_sel,
  input  logic             port_bit,
  input  logic [CNT_W-1:0] count,
  input  logic             dir_down,
  input  logic             at_top,
  input  logic [CNT_W-1:0] ocr,
  output logic             pin
);

  logic wave_q;
  logic wave_nxt;
  logic connect;
  logic match;
  logic down_evt;

  always_comb begin
    match    = (count == ocr);
    // a match at the turning point counts as a falling-slope match
    down_evt = dir_down | at_top;
    wave_nxt = wave_q;
    connect  = 1'b0;
    unique case (out_mode_e'(mode))
      OM_PORT: begin
        connect = 1'b0;
      end
      OM_TOGGLE: begin
        if (TOGGLE_OK && toggle_sel) begin
          connect = 1'b1;
          if (match) wave_nxt = ~wave_q;
        end
      end
      OM_CLR_UP: begin
        connect = 1'b1;
        if (match) wave_nxt = down_evt;
      end
      OM_SET_UP: begin
        connect = 1'b1;
        if (match) wave_nxt = ~down_evt;
      end
      default: begin
        connect = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      pin    <= 1'b0;
    end else begin
      wave_q <= wave_nxt;
      pin    <= connect ? wave_nxt : port_bit;
    end
  end

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pwm_ds_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] top_val,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             a_toggle_en,
  input  logic             port_a,
  input  logic             port_b,
  output logic             pin_a,
  output logic             pin_b,
  output logic [CNT_W-1:0] count,
  output logic             dir_down
);

  logic                              at_top;
  logic [NUM_CH-1:0][CNT_W-1:0]      cmp_in;
  logic [NUM_CH-1:0][CNT_W-1:0]      ocr_q;
  logic [NUM_CH-1:0][1:0]            mode_in;
  logic [NUM_CH-1:0]                 port_in;
  logic [NUM_CH-1:0]                 pin_w;

  assign cmp_in  = {cmp_b, cmp_a};
  assign mode_in = {mode_b, mode_a};
  assign port_in = {port_b, port_a};
  assign pin_a   = pin_w[0];
  assign pin_b   = pin_w[1];

  pwm_ds_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .top_val  (top_val),
    .count    (count),
    .dir_down (dir_down),
    .at_top   (at_top)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_ds_cmp_buf #(.CNT_W(CNT_W)) u_buf (
      .clk   (clk),
      .rst   (rst),
      .load  (at_top),
      .din   (cmp_in[ch]),
      .ocr_q (ocr_q[ch])
    );

    pwm_ds_wave_ch #(
      .CNT_W     (CNT_W),
      .TOGGLE_OK (ch == 0)
    ) u_wave (
      .clk        (clk),
      .rst        (rst),
      .mode       (mode_in[ch]),
      .toggle_sel (a_toggle_en),
      .port_bit   (port_in[ch]),
      .count      (count),
      .dir_down   (dir_down),
      .at_top     (at_top),
      .ocr        (ocr_q[ch]),
      .pin        (pin_w[ch])
    );
  end

endmodule

// File: rtl/pwm_ds_chk.sv
module pwm_ds_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] top_val,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic             port_a,
  input logic             port_b,
  input logic             pin_a,
  input logic             pin_b,
  input logic [CNT_W-1:0] count,
  input logic             dir_down,
  input logic [CNT_W-1:0] ocr_a,
  input logic [CNT_W-1:0] ocr_b
);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (count <= top_val && $stable(top_val)) |=> count <= top_val); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (top_val != '0 && $stable(top_val) && count <= top_val)
      |=> (count == $past(count) + 1'b1 || count + 1'b1 == $past(count))); // R1

  AST_TURN_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    ($rose(dir_down) && $stable(top_val)) |-> count == top_val); // R2

  AST_TURN_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(dir_down) |-> count == '0); // R2

  AST_PORT_PASS_A: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'b00) |=> pin_a == $past(port_a)); // R3

  AST_B_NO_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (mode_b == 2'b01) |=> pin_b == $past(port_b)); // R4

  AST_CLR_ON_UP: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'b10 && count == ocr_a && !dir_down && count != top_val) |=> !pin_a); // R5

  AST_SET_ON_UP: assert property (@(posedge clk) disable iff (rst)
    (mode_b == 2'b11 && count == ocr_b && !dir_down && count != top_val) |=> pin_b); // R6

  AST_TOP_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'b10 && ocr_a == top_val && count == top_val) |=> pin_a); // R7

  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (count != top_val) |=> ($stable(ocr_a) && $stable(ocr_b))); // R8

endmodule

bind pwm_dual_slope pwm_ds_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .top_val  (top_val),
  .mode_a   (mode_a),
  .mode_b   (mode_b),
  .port_a   (port_a),
  .port_b   (port_b),
  .pin_a    (pin_a),
  .pin_b    (pin_b),
  .count    (count),
  .dir_down (dir_down),
  .ocr_a    (ocr_q[0]),
  .ocr_b    (ocr_q[1])
);

// File: tb/tb_pwm_dual_slope.sv
module tb_pwm_dual_slope;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] top_val = '0;
  logic [W-1:0] cmp_a = '0;
  logic [W-1:0] cmp_b = '0;
  logic [1:0]   mode_a = 2'b00;
  logic [1:0]   mode_b = 2'b00;
  logic         a_toggle_en = 1'b0;
  logic         port_a = 1'b0;
  logic         port_b = 1'b0;
  logic         pin_a;
  logic         pin_b;
  logic [W-1:0] count;
  logic         dir_down;

  pwm_dual_slope #(.CNT_W(W)) dut (
    .clk         (clk),
    .rst         (rst),
    .top_val     (top_val),
    .cmp_a       (cmp_a),
    .cmp_b       (cmp_b),
    .mode_a      (mode_a),
    .mode_b      (mode_b),
    .a_toggle_en (a_toggle_en),
    .port_a      (port_a),
    .port_b      (port_b),
    .pin_a       (pin_a),
    .pin_b       (pin_b),
    .count       (count),
    .dir_down    (dir_down)
  );

  always #5 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  int t_top  = 0;
  int m_cnt, m_dn, m_oa, m_ob, m_tw;
  bit exp_a, exp_b;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  function automatic bit lvl(input logic [1:0] md, input bit is_a, input bit tg,
                             input int c, input int d, input int o,
                             input bit prt, input int tw);
    case (md)
      2'b00:   return prt;
      2'b01:   return (is_a && tg) ? (tw != 0) : prt;
      2'b10:   return (d != 0) ? (c <= o) : (c < o);
      default: return (d != 0) ? (c > o) : (c >= o);
    endcase
  endfunction

  task automatic rand_ports();
    lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    port_a = lfsr[0];
    port_b = lfsr[3];
  endtask

  task automatic do_reset();
    top_val = W'(t_top);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_dn = 0; m_oa = 0; m_ob = 0; m_tw = 0;
  endtask

  // called just after a falling edge with inputs already applied
  task automatic tick(input bit chk_pins, input string tag_a, input string tag_b);
    int n_cnt, n_dn, n_oa, n_ob, n_tw;
    if (t_top == 0) begin
      n_cnt = 0; n_dn = 0;
    end else if (m_dn == 0) begin
      if (m_cnt + 1 >= t_top) begin n_cnt = t_top; n_dn = 1; end
      else begin n_cnt = m_cnt + 1; n_dn = 0; end
    end else begin
      if (m_cnt <= 1) begin n_cnt = 0; n_dn = 0; end
      else begin n_cnt = m_cnt - 1; n_dn = 1; end
    end
    n_oa  = (m_cnt == t_top) ? int'(cmp_a) : m_oa;
    n_ob  = (m_cnt == t_top) ? int'(cmp_b) : m_ob;
    n_tw  = (m_cnt == m_oa) ? 1 - m_tw : m_tw;
    exp_a = lvl(mode_a, 1'b1, a_toggle_en, m_cnt, m_dn, m_oa, port_a, n_tw);
    exp_b = lvl(mode_b, 1'b0, a_toggle_en, m_cnt, m_dn, m_ob, port_b, 0);
    @(negedge clk);
    m_cnt = n_cnt; m_dn = n_dn; m_oa = n_oa; m_ob = n_ob; m_tw = n_tw;
    check("R1 count", int'(count), m_cnt);
    check("R2 dir_down", int'(dir_down), m_dn);
    if (chk_pins) begin
      check({tag_a, " pin_a"}, int'(pin_a), int'(exp_a));
      check({tag_b, " pin_b"}, int'(pin_b), int'(exp_b));
    end
  endtask

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    int tops_c[5] = '{0, 1, 2, 5, 15};
    int tops_w[3] = '{3, 7, 15};
    string ta, tb;

    // R10: reset state with port bits high and compare inputs nonzero
    port_a = 1'b1; port_b = 1'b1; cmp_a = 4'd3; cmp_b = 4'd5;
    t_top = 7;
    do_reset();
    rst = 1'b1;
    check("R10 count", int'(count), 0);
    check("R10 dir_down", int'(dir_down), 0);
    check("R10 pin_a", int'(pin_a), 0);
    check("R10 pin_b", int'(pin_b), 0);
    // R10: internal compare value 0 after reset -> first toggle at count 0
    mode_a = 2'b01; a_toggle_en = 1'b1; port_a = 1'b0;
    do_reset();
    tick(1'b1, "R10", "R3");

    // R1 R2: counter sweep over several turning points
    mode_a = 2'b00; a_toggle_en = 1'b0;
    foreach (tops_c[i]) begin
      t_top = tops_c[i];
      do_reset();
      repeat (6 * (t_top + 1) + 4) tick(1'b0, "", "");
    end

    // R3: port passthrough on both channels
    t_top = 5; mode_a = 2'b00; mode_b = 2'b00;
    do_reset();
    repeat (40) begin rand_ports(); tick(1'b1, "R3", "R3"); end

    // R4: code 01 with toggle disabled passes port data
    mode_a = 2'b01; mode_b = 2'b01; a_toggle_en = 1'b0;
    repeat (30) begin rand_ports(); tick(1'b1, "R4", "R4"); end

    // R4: toggle enabled, A toggles on every match, B still passthrough
    t_top = 7; cmp_a = 4'd3; cmp_b = 4'd3; a_toggle_en = 1'b1;
    do_reset();
    repeat (60) begin rand_ports(); tick(1'b1, "R4", "R4"); end
    a_toggle_en = 1'b0;
    port_a = 1'b0; port_b = 1'b0;

    // R5 R6 R7: sweep of compare values on both slopes
    foreach (tops_w[i]) begin
      for (int pass = 0; pass < 2; pass++) begin
        for (int o = 0; o <= tops_w[i]; o++) begin
          t_top  = tops_w[i];
          cmp_a  = W'(o); cmp_b = W'(o);
          mode_a = (pass == 0) ? 2'b10 : 2'b11;
          mode_b = (pass == 0) ? 2'b11 : 2'b10;
          do_reset();
          repeat (4 * t_top + 2) tick(1'b0, "", "");
          if (o == 0 || o == t_top) begin ta = "R7"; tb = "R7"; end
          else if (pass == 0) begin ta = "R5"; tb = "R6"; end
          else begin ta = "R6"; tb = "R5"; end
          repeat (2 * t_top + 2) tick(1'b1, ta, tb);
        end
      end
    end

    // R8: compare change takes effect only after the turning point
    t_top = 7; cmp_a = 4'd2; mode_a = 2'b10; mode_b = 2'b00;
    do_reset();
    repeat (30) tick(1'b0, "", "");
    while (!(m_cnt == 3 && m_dn == 0)) tick(1'b1, "R8", "R3");
    cmp_a = 4'd5;
    repeat (10) tick(1'b1, "R8", "R3");
    while (!(m_cnt == 4 && m_dn == 1)) tick(1'b1, "R8", "R3");
    cmp_a = 4'd1;
    repeat (30) tick(1'b1, "R8", "R3");

    // R9: compare value above TOP never matches
    t_top = 7; cmp_a = 4'd9; cmp_b = 4'd12; mode_a = 2'b10; mode_b = 2'b11;
    do_reset();
    repeat (2) tick(1'b0, "", "");
    repeat (40) begin
      tick(1'b0, "", "");
      check("R9 pin_a", int'(pin_a), 0);
      check("R9 pin_b", int'(pin_b), 1);
    end

    report();
    $finish;
  end

endmodule